// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Compare and Select

This block is a purely combinational unit for signed fixed-point data in which each operand carries its own format, fixed at compile time. A format is a raw width and a power-of-two exponent, so a raw word `r` with exponent `e` stands for `r * 2^e`. A bitwise compare or a plain multiplexer would give wrong answers across such operands. Instead, two operands are brought to the finer of their two exponents before they are ordered. Six relational flags, a minimum and a maximum are derived from that shared view.

A separate conditional path takes a one-bit condition and two candidate values, each in its own format. It rescales the chosen candidate into a third output format. Going to a coarser exponent truncates toward negative infinity. Going to a finer one shifts in zeros at the low end. Every output settles in the same cycle as the inputs, so the unit can sit between pipeline registers of a larger datapath.

Top module: `fxp_cmpsel`

## Requirements
- R1: With default formats (left operand 8 bits, exponent -4; right operand 7 bits, exponent -2), `lt_o`, `le_o`, `gt_o` and `ge_o` are each 1 exactly when the relation "left operand versus right operand" holds on the represented values, and 0 otherwise.
- R2: `eq_o` is 1 and `ne_o` is 0 only when the two represented values are exactly equal. Values that differ only below the coarser operand's resolution compare as unequal.
- R3: Both operands are sign-extended and shifted to the smaller exponent (default -4, common width 9 bits) before ordering, so no fractional bit of the finer operand is dropped and negative values keep their order.
- R4: `min_o` and `max_o` carry the smaller and the larger operand in the common format (default 9 bits, exponent -4). When the operands are equal, both carry the left operand.
- R5: `sel_o` carries the rescaled true-value when `cond_i` is 1 and the rescaled false-value when `cond_i` is 0. The candidate that is not chosen has no effect on `sel_o`.
- R6: A candidate with a finer exponent than the output (default true-value 8 bits, exponent -3, into output 8 bits, exponent -2) is arithmetically right-shifted, which truncates toward negative infinity (for example, raw -13 gives raw -7).
- R7: A candidate with a coarser exponent than the output (default false-value 6 bits, exponent 0) is sign-extended and left-shifted with zero fill (for example, raw -32 gives raw -128).
- R8: All outputs follow input changes combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs_i | input | L_W | Left operand, raw signed word, exponent L_EXP |
| rhs_i | input | R_W | Right operand, raw signed word, exponent R_EXP |
| lt_o | output | 1 | Left below right |
| le_o | output | 1 | Left below or equal to right |
| gt_o | output | 1 | Left above right |
| ge_o | output | 1 | Left above or equal to right |
| eq_o | output | 1 | Exact equality |
| ne_o | output | 1 | Inequality |
| min_o | output | common width | Smaller operand, common exponent |
| max_o | output | common width | Larger operand, common exponent |
| cond_i | input | 1 | Select condition |
| tval_i | input | T_W | Candidate when condition is 1, exponent T_EXP |
| fval_i | input | F_W | Candidate when condition is 0, exponent F_EXP |
| sel_o | output | Y_W | Chosen candidate, exponent Y_EXP |

## Verification
Ordering and selection share no logic, but both can change in the same cycle. Every table vector therefore drives new operands and a new condition with new candidates at once, and the bench checks the flags, min, max and selection together against values it works out from the represented numbers. Min and max also settle together from one comparison, so each vector judges both against the same expected order, including the equal case, where both must match the left operand.

// File: rtl/fxp_cmpsel_pkg.sv
package fxp_cmpsel_pkg;

    typedef struct packed {
        logic lt;
        logic le;
        logic gt;
        logic ge;
        logic eq;
        logic ne;
    } rel_flags_t;

    function automatic int exp_min(input int ea, input int eb);
        return (ea < eb) ? ea : eb;
    endfunction

    // width that holds an operand once shifted down to exponent ce
    function automatic int grown_width(input int w, input int e, input int ce);
        return w + (e - ce);
    endfunction

    function automatic int common_width(input int wa, input int ea,
                                        input int wb, input int eb);
        int ce;
        int ga;
        int gb;
        ce = exp_min(ea, eb);
        ga = grown_width(wa, ea, ce);
        gb = grown_width(wb, eb, ce);
        return (ga > gb) ? ga : gb;
    endfunction

endpackage

// File: rtl/fxp_rescale.sv
module fxp_rescale #(
    parameter int IN_W    = 8,
    parameter int IN_EXP  = 0,
    parameter int OUT_W   = 8,
    parameter int OUT_EXP = 0
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] val_o
);
    localparam int LSH = (IN_EXP > OUT_EXP) ? (IN_EXP - OUT_EXP) : 0;
    localparam int RSH = (OUT_EXP > IN_EXP) ? (OUT_EXP - IN_EXP) : 0;
    localparam int WW  = IN_W + LSH + OUT_W;

    logic signed [WW-1:0] ext;
    logic signed [WW-1:0] moved;

    assign ext = {{(WW-IN_W){val_i[IN_W-1]}}, val_i};

    generate
        if (LSH > 0) begin : g_up
            assign moved = ext <<< LSH;
        end else begin : g_down
            assign moved = ext >>> RSH;
            if (RSH > 0 && OUT_W >= IN_W - RSH) begin : g_chk
                // floor shift keeps the sign of the source
                always_comb begin
                    assert_sign_kept_R6: assert (val_o[OUT_W-1] == val_i[IN_W-1])
                        else $error("rescale changed sign");
                end
            end
        end
    endgenerate

    assign val_o = moved[OUT_W-1:0];

endmodule

// File: rtl/fxp_relate.sv
module fxp_relate
    import fxp_cmpsel_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic signed [CW-1:0] a_i,
    input  logic signed [CW-1:0] b_i,
    output rel_flags_t           flags_o
);
    logic below;
    logic same;

    assign below = (a_i < b_i);
    assign same  = (a_i == b_i);

    always_comb begin
        flags_o.lt = below;
        flags_o.eq = same;
        flags_o.gt = !below && !same;
        flags_o.le = below || same;
        flags_o.ge = !below;
        flags_o.ne = !same;
    end

    always_comb begin
        assert_trichotomy_R1: assert ($countones({flags_o.lt, flags_o.eq, flags_o.gt}) == 1)
            else $error("ordering flags not exclusive");
        assert_eq_exact_R2: assert (flags_o.eq == (a_i == b_i))
            else $error("equality flag disagrees with aligned words");
    end

endmodule

// File: rtl/fxp_minmax.sv
module fxp_minmax
    import fxp_cmpsel_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic signed [CW-1:0] a_i,
    input  logic signed [CW-1:0] b_i,
    input  rel_flags_t           flags_i,
    output logic signed [CW-1:0] min_o,
    output logic signed [CW-1:0] max_o
);
    // ties keep the left operand on both outputs
    assign min_o = flags_i.gt ? b_i : a_i;
    assign max_o = flags_i.lt ? b_i : a_i;

    always_comb begin
        assert_order_R4: assert (min_o <= max_o)
            else $error("min above max");
        assert_origin_R4: assert ((min_o == a_i || min_o == b_i) &&
                                  (max_o == a_i || max_o == b_i))
            else $error("min/max not drawn from operands");
    end

endmodule

// File: rtl/fxp_cmpsel.sv
module fxp_cmpsel
    import fxp_cmpsel_pkg::*;
#(
    parameter int L_W   = 8,
    parameter int L_EXP = -4,
    parameter int R_W   = 7,
    parameter int R_EXP = -2,
    parameter int T_W   = 8,
    parameter int T_EXP = -3,
    parameter int F_W   = 6,
    parameter int F_EXP = 0,
    parameter int Y_W   = 8,
    parameter int Y_EXP = -2
) (
    input  logic signed [L_W-1:0] lhs_i,
    input  logic signed [R_W-1:0] rhs_i,
    output logic                  lt_o,
    output logic                  le_o,
    output logic                  gt_o,
    output logic                  ge_o,
    output logic                  eq_o,
    output logic                  ne_o,
    output logic signed [fxp_cmpsel_pkg::common_width(L_W, L_EXP, R_W, R_EXP)-1:0] min_o,
    output logic signed [fxp_cmpsel_pkg::common_width(L_W, L_EXP, R_W, R_EXP)-1:0] max_o,
    input  logic                  cond_i,
    input  logic signed [T_W-1:0] tval_i,
    input  logic signed [F_W-1:0] fval_i,
    output logic signed [Y_W-1:0] sel_o
);
    localparam int CE = exp_min(L_EXP, R_EXP);
    localparam int CW = common_width(L_W, L_EXP, R_W, R_EXP);

    logic signed [CW-1:0]  lhs_al;
    logic signed [CW-1:0]  rhs_al;
    logic signed [Y_W-1:0] t_al;
    logic signed [Y_W-1:0] f_al;
    rel_flags_t            flags;

    fxp_rescale #(.IN_W(L_W), .IN_EXP(L_EXP), .OUT_W(CW), .OUT_EXP(CE)) u_al_lhs (
        .val_i(lhs_i), .val_o(lhs_al));
    fxp_rescale #(.IN_W(R_W), .IN_EXP(R_EXP), .OUT_W(CW), .OUT_EXP(CE)) u_al_rhs (
        .val_i(rhs_i), .val_o(rhs_al));

    fxp_relate #(.CW(CW)) u_relate (
        .a_i(lhs_al), .b_i(rhs_al), .flags_o(flags));

    fxp_minmax #(.CW(CW)) u_minmax (
        .a_i(lhs_al), .b_i(rhs_al), .flags_i(flags),
        .min_o(min_o), .max_o(max_o));

    fxp_rescale #(.IN_W(T_W), .IN_EXP(T_EXP), .OUT_W(Y_W), .OUT_EXP(Y_EXP)) u_al_t (
        .val_i(tval_i), .val_o(t_al));
    fxp_rescale #(.IN_W(F_W), .IN_EXP(F_EXP), .OUT_W(Y_W), .OUT_EXP(Y_EXP)) u_al_f (
        .val_i(fval_i), .val_o(f_al));

    assign sel_o = cond_i ? t_al : f_al;

    assign lt_o = flags.lt;
    assign le_o = flags.le;
    assign gt_o = flags.gt;
    assign ge_o = flags.ge;
    assign eq_o = flags.eq;
    assign ne_o = flags.ne;

    always_comb begin
        assert_min_follows_lt_R4: assert (!flags.lt || (min_o == lhs_al && max_o == rhs_al))
            else $error("min/max disagree with less-than");
        assert_tie_left_R4: assert (!flags.eq || (min_o == lhs_al && max_o == lhs_al))
            else $error("tie did not return left operand");
    end

endmodule

// File: tb/fxp_cmpsel_bench.sv
module fxp_cmpsel_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              cond;
    logic signed [7:0] lhs;
    logic signed [6:0] rhs;
    logic signed [7:0] tval;
    logic signed [5:0] fval;
    logic lt, le, gt, ge, eq, ne;
    logic signed [8:0] mn;
    logic signed [8:0] mx;
    logic signed [7:0] sel;

    fxp_cmpsel u_fxp_cmpsel (
        .lhs_i(lhs), .rhs_i(rhs),
        .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge), .eq_o(eq), .ne_o(ne),
        .min_o(mn), .max_o(mx),
        .cond_i(cond), .tval_i(tval), .fval_i(fval), .sel_o(sel));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // lhs raw, rhs raw, flags {lt,le,gt,ge,eq,ne}, min, max (exponent -4)
    localparam int VEC [8][5] = '{
        '{  16,   4, 6'b010110,   16,  16},
        '{  17,   4, 6'b001101,   16,  17},
        '{-128,  63, 6'b110001, -128, 252},
        '{   0, -64, 6'b001101, -256,   0},
        '{  -1,   0, 6'b110001,   -1,   0},
        '{ 127,  -1, 6'b001101,   -4, 127},
        '{  15,   4, 6'b110001,   15,  16},
        '{ -16,  -4, 6'b010110,  -16, -16}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int floor_half(input int v);
        return (v < 0) ? -((1 - v) / 2) : v / 2;
    endfunction

    initial begin
        cond = 0; lhs = 0; rhs = 0; tval = 0; fval = 0;
        @(negedge clk);
        // idle state with all inputs zero
        chk("R2 idle flags", int'({lt,le,gt,ge,eq,ne}), 6'b010110);
        chk("R4 idle min", int'(mn), 0);
        chk("R5 idle sel", int'(sel), 0);

        // table walk: compare and select change together
        for (int i = 0; i < 8; i++) begin
            int t;
            int f;
            int es;
            t = i * 9 - 30;
            f = i - 8;
            es = i[0] ? floor_half(t) : f * 4;
            @(posedge clk);
            lhs  = 8'(VEC[i][0]);
            rhs  = 7'(VEC[i][1]);
            cond = i[0];
            tval = 8'(t);
            fval = 6'(f);
            @(negedge clk);
            chk("R1 R2 R3 flags", int'({lt,le,gt,ge,eq,ne}), VEC[i][2]);
            chk("R4 min", int'(mn), VEC[i][3]);
            chk("R4 max", int'(mx), VEC[i][4]);
            chk("R5 R6 R7 sel", int'(sel), es);
        end

        // R5: unchosen candidate has no effect
        @(posedge clk); cond = 1; tval = 13; fval = 0;
        @(negedge clk); chk("R6 tval 13", int'(sel), 6);
        fval = 31; #1; chk("R5 fval ignored", int'(sel), 6);
        cond = 0; #1; chk("R7 fval 31", int'(sel), 124);
        tval = -100; #1; chk("R5 tval ignored", int'(sel), 124);
        // R6: floor truncation and extremes
        cond = 1; tval = -13; #1; chk("R6 tval -13", int'(sel), -7);
        tval = 127; #1; chk("R6 tval 127", int'(sel), 63);
        tval = -128; #1; chk("R6 tval -128", int'(sel), -64);
        tval = -1; #1; chk("R6 tval -1", int'(sel), -1);
        // R7: most negative false-value
        cond = 0; fval = -32; #1; chk("R7 fval -32", int'(sel), -128);

        // R8: change mid-cycle, no clock edge in between
        @(posedge clk); #1;
        lhs = 3; rhs = 1; #0.5;
        chk("R8 mid-cycle lt", int'(lt), 1);
        chk("R3 fine bits kept max", int'(mx), 4);
        lhs = 4; #0.5;
        chk("R8 mid-cycle eq", int'(eq), 1);
        chk("R1 le on equal", int'(le), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule